// File: doc/BRIEF.md
# Block-Committed IP Data FIFO Pair

This block sits between a register-mapped data window and a serial engine and holds two FIFOs of 64-bit entries: one carrying data toward the engine (transmit) and one carrying data from it (receive). Software does not move data one entry at a time. It stages a block in a transmit window of 32-bit words and commits the whole block with a single push pulse, which models writing 1 to the transmit room flag. On the receive side it reads a block through a 32-bit window and releases it with a single pop pulse, which models writing 1 to the receive available flag. Each side has a programmable block size, called the watermark. Fill levels are counted in 64-bit entries, that is in 8-byte units.

Each side has a room or availability flag, a fill level and a flush request. A flush arms on one clock and empties the FIFO on the next. For the last stretch of a transfer, software can commit a shorter block of any length. A push that finds too little room is dropped, and so is a pop that finds too few entries. Either one raises a one-cycle error pulse. On the engine side, entries move one at a time.

Top module: `wm_ip_fifo`

## Requirements
- R1: After reset both fill levels are 0, `tx_wm_room` is 1, `rx_wm_avail` is 0, both flush-busy outputs are 0, both error pulses are 0, and both watermark fields are 0.
- R2: A watermark field value f, written through `tx_wm_we`/`rx_wm_we` with `wm_wdata`, sets a block of f+1 entries, which is 8·(f+1) bytes or 2·(f+1) window words. The reset value 0 gives 8-byte blocks. A written value applies from the next cycle.
- R3: A `tx_push` with `blk_partial`=0 appends f+1 entries to the transmit FIFO. Entry k is built as {window word 2k+1, window word 2k}, with the odd word in bits 63:32. `tx_fill` reports occupancy in entries.
- R4: `tx_wm_room` is 1 exactly when DEPTH − `tx_fill` ≥ f_tx+1.
- R5: `rx_wm_avail` is 1 exactly when `rx_fill` ≥ f_rx+1.
- R6: `rx_win_rdata` for index i returns entry i/2 counted from the oldest receive entry: bits 31:0 when i is even, bits 63:32 when i is odd. A `rx_pop` with `blk_partial`=0 removes f_rx+1 entries.
- R7: With `blk_partial`=1, a push or pop moves `blk_part_len`+1 entries instead of a watermark block.
- R8: A push whose length exceeds the free entries is dropped whole, and `tx_ovf` is 1 for exactly the following cycle.
- R9: A pop whose length exceeds `rx_fill` is dropped whole, and `rx_unf` is 1 for exactly the following cycle.
- R10: A flush pulse sets the side's flush-busy output in the next cycle. On the clock after that the FIFO empties and busy clears. Every push and pop presented in that emptying cycle is discarded and raises no error.
- R11: `eng_tx_data` shows the oldest transmit entry, and `eng_tx_pop` removes one entry. `eng_rx_push` appends `eng_rx_data`. An engine pop from an empty FIFO or an engine push into a full one has no effect and raises no error.
- R12: A software operation and an engine operation on the same FIFO in the same cycle both take effect, and each is judged against the occupancy before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wm_we | input | 1 | Write transmit watermark field |
| rx_wm_we | input | 1 | Write receive watermark field |
| wm_wdata | input | AW | Watermark field value (block entries − 1) |
| tx_win_we | input | 1 | Write one transmit window word |
| tx_win_idx | input | AW+1 | Transmit window word index |
| tx_win_wdata | input | WORD_W | Transmit window word data |
| tx_push | input | 1 | Commit staged block to transmit FIFO |
| rx_pop | input | 1 | Release block from receive FIFO |
| blk_partial | input | 1 | Use `blk_part_len` instead of the watermark |
| blk_part_len | input | AW | Partial block length − 1 |
| tx_flush | input | 1 | Request transmit flush |
| rx_flush | input | 1 | Request receive flush |
| rx_win_idx | input | AW+1 | Receive window word index |
| eng_tx_pop | input | 1 | Engine consumes one transmit entry |
| eng_rx_push | input | 1 | Engine delivers one receive entry |
| eng_rx_data | input | 2·WORD_W | Receive entry from engine |
| rx_win_rdata | output | WORD_W | Receive window word |
| tx_wm_room | output | 1 | Room for one transmit block |
| rx_wm_avail | output | 1 | One receive block available |
| tx_fill | output | AW+1 | Transmit occupancy in entries |
| rx_fill | output | AW+1 | Receive occupancy in entries |
| tx_flush_busy | output | 1 | Transmit flush armed |
| rx_flush_busy | output | 1 | Receive flush armed |
| tx_ovf | output | 1 | Dropped push pulse |
| rx_unf | output | 1 | Dropped pop pulse |
| eng_tx_data | output | 2·WORD_W | Oldest transmit entry |

## Verification
Full-size transmit blocks are pushed until the FIFO is full, which separates the room threshold from plain fullness. One more push then shows that a dropped block leaves the level unchanged. Draining through the engine, including a pop from empty, checks entry order and the half-word packing. Partial pushes and pops, and a watermark spanning the whole depth, exercise the length selection. Simultaneous software and engine operations, one of them on a full receive FIFO, show that both checks use the occupancy from before the edge. Flushes with an operation in the emptying cycle show that such operations are discarded.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
   typedef enum logic {
      FL_RUN   = 1'b0,
      FL_ARMED = 1'b1
   } flush_st_e;
endpackage

// File: rtl/wmf_ctrl.sv
module wmf_ctrl
   import wmf_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter bit SW_WRITES = 1'b1,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_req,
   input  logic             wm_we,
   input  logic [AW-1:0]    wm_wdata,
   input  logic             sw_req,
   input  logic             blk_partial,
   input  logic [AW-1:0]    blk_part_len,
   input  logic             eng_req,
   output logic [AW-1:0]    wr_ptr_o,
   output logic [AW-1:0]    rd_ptr_o,
   output logic [CNT_W-1:0] fill_o,
   output logic             flag_o,
   output logic             busy_o,
   output logic             err_o,
   output logic             sw_fire_o,
   output logic [CNT_W-1:0] sw_n_o,
   output logic             eng_fire_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wmf_ctrl: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] wr_q, rd_q;
   logic [AW-1:0]    field_q;
   flush_st_e        fl_q;
   logic             err_q;

   logic [CNT_W-1:0] free_n, full_n, blk_n;
   logic             wr_req, rd_req, wr_ok, rd_ok, flushing;
   logic [CNT_W-1:0] wr_n, rd_n;

   assign flushing = (fl_q == FL_ARMED);
   assign fill_o   = wr_q - rd_q;
   assign free_n   = CNT_W'(DEPTH) - fill_o;
   assign full_n   = CNT_W'(field_q) + CNT_W'(1);
   assign blk_n    = blk_partial ? (CNT_W'(blk_part_len) + CNT_W'(1)) : full_n;

   generate
      if (SW_WRITES) begin : g_sw_writes
         assign wr_req     = sw_req;
         assign wr_n       = blk_n;
         assign rd_req     = eng_req;
         assign rd_n       = CNT_W'(1);
         assign sw_fire_o  = wr_ok;
         assign eng_fire_o = rd_ok;
         assign flag_o     = (free_n >= full_n);
      end else begin : g_sw_reads
         assign wr_req     = eng_req;
         assign wr_n       = CNT_W'(1);
         assign rd_req     = sw_req;
         assign rd_n       = blk_n;
         assign sw_fire_o  = rd_ok;
         assign eng_fire_o = wr_ok;
         assign flag_o     = (fill_o >= full_n);
      end
   endgenerate

   assign wr_ok = wr_req && !flushing && (free_n >= wr_n);
   assign rd_ok = rd_req && !flushing && (fill_o >= rd_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_q    <= '0;
         field_q <= '0;
         fl_q    <= FL_RUN;
         err_q   <= 1'b0;
      end else begin
         if (wm_we) field_q <= wm_wdata;
         if (flushing) begin
            wr_q  <= '0;
            rd_q  <= '0;
            fl_q  <= FL_RUN;
            err_q <= 1'b0;
         end else begin
            wr_q  <= wr_q + (wr_ok ? wr_n : '0);
            rd_q  <= rd_q + (rd_ok ? rd_n : '0);
            fl_q  <= flush_req ? FL_ARMED : FL_RUN;
            err_q <= sw_req && !sw_fire_o;
         end
      end
   end

   assign wr_ptr_o = wr_q[AW-1:0];
   assign rd_ptr_o = rd_q[AW-1:0];
   assign busy_o   = flushing;
   assign err_o    = err_q;
   assign sw_n_o   = blk_n;

   // R3 / R6: occupancy never exceeds the depth
   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_o <= CNT_W'(DEPTH));
   // R10: an armed flush empties the FIFO on the next edge and disarms
   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (fill_o == '0) && !busy_o);
   // R8 (transmit) / R9 (receive): an error pulse follows a software request
   p_err_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(sw_req));
   // R8 / R9: a dropped request alone leaves the occupancy unchanged
   p_reject_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && !sw_fire_o && !eng_fire_o && !busy_o) |=> $stable(fill_o));
endmodule

// File: rtl/wmf_tx_store.sv
module wmf_tx_store #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int AW      = $clog2(DEPTH),
   localparam int CNT_W   = AW + 1,
   localparam int WIN_W   = AW + 1,
   localparam int WIN_N   = 2 * DEPTH,
   localparam int ENTRY_W = 2 * WORD_W
) (
   input  logic               clk,
   input  logic               win_we,
   input  logic [WIN_W-1:0]   win_idx,
   input  logic [WORD_W-1:0]  win_wdata,
   input  logic               push_fire,
   input  logic [CNT_W-1:0]   push_n,
   input  logic [AW-1:0]      wr_ptr,
   input  logic [AW-1:0]      rd_ptr,
   output logic [ENTRY_W-1:0] head_data
);
   logic [WORD_W-1:0]  stage_q [WIN_N];
   logic [ENTRY_W-1:0] slot_rd [DEPTH];

   always_ff @(posedge clk) begin
      if (win_we) stage_q[win_idx] <= win_wdata;
   end

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic [ENTRY_W-1:0] slot_q;
         logic [AW-1:0]      off;
         assign off = AW'(s) - wr_ptr;
         always_ff @(posedge clk) begin
            if (push_fire && ({1'b0, off} < push_n))
               slot_q <= {stage_q[{off, 1'b1}], stage_q[{off, 1'b0}]};
         end
         assign slot_rd[s] = slot_q;
      end
   endgenerate

   assign head_data = slot_rd[rd_ptr];
endmodule

// File: rtl/wmf_rx_store.sv
module wmf_rx_store #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int AW      = $clog2(DEPTH),
   localparam int WIN_W   = AW + 1,
   localparam int ENTRY_W = 2 * WORD_W
) (
   input  logic               clk,
   input  logic               wr_fire,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [AW-1:0]      wr_ptr,
   input  logic [AW-1:0]      rd_ptr,
   input  logic [WIN_W-1:0]   win_idx,
   output logic [WORD_W-1:0]  win_rdata
);
   logic [ENTRY_W-1:0] mem_q [DEPTH];
   logic [AW-1:0]      sel;
   logic [ENTRY_W-1:0] ent;

   always_ff @(posedge clk) begin
      if (wr_fire) mem_q[wr_ptr] <= wr_data;
   end

   assign sel       = rd_ptr + win_idx[WIN_W-1:1];
   assign ent       = mem_q[sel];
   assign win_rdata = win_idx[0] ? ent[ENTRY_W-1:WORD_W] : ent[WORD_W-1:0];
endmodule

// File: rtl/wm_ip_fifo.sv
module wm_ip_fifo #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int AW      = $clog2(DEPTH),
   localparam int CNT_W   = AW + 1,
   localparam int WIN_W   = AW + 1,
   localparam int ENTRY_W = 2 * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_wm_we,
   input  logic               rx_wm_we,
   input  logic [AW-1:0]      wm_wdata,
   input  logic               tx_win_we,
   input  logic [WIN_W-1:0]   tx_win_idx,
   input  logic [WORD_W-1:0]  tx_win_wdata,
   input  logic               tx_push,
   input  logic               rx_pop,
   input  logic               blk_partial,
   input  logic [AW-1:0]      blk_part_len,
   input  logic               tx_flush,
   input  logic               rx_flush,
   input  logic [WIN_W-1:0]   rx_win_idx,
   input  logic               eng_tx_pop,
   input  logic               eng_rx_push,
   input  logic [ENTRY_W-1:0] eng_rx_data,
   output logic [WORD_W-1:0]  rx_win_rdata,
   output logic               tx_wm_room,
   output logic               rx_wm_avail,
   output logic [CNT_W-1:0]   tx_fill,
   output logic [CNT_W-1:0]   rx_fill,
   output logic               tx_flush_busy,
   output logic               rx_flush_busy,
   output logic               tx_ovf,
   output logic               rx_unf,
   output logic [ENTRY_W-1:0] eng_tx_data
);
   generate
      if (WORD_W < 8) begin : g_bad_word
         $error("wm_ip_fifo: WORD_W must be at least 8");
      end
   endgenerate

   logic [AW-1:0]    tx_wr, tx_rd, rx_wr, rx_rd;
   logic             tx_sw_fire, tx_eng_fire, rx_sw_fire, rx_eng_fire;
   logic [CNT_W-1:0] tx_sw_n, rx_sw_n;

   wmf_ctrl #(.DEPTH(DEPTH), .SW_WRITES(1'b1)) u_tx_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_req    (tx_flush),
      .wm_we        (tx_wm_we),
      .wm_wdata     (wm_wdata),
      .sw_req       (tx_push),
      .blk_partial  (blk_partial),
      .blk_part_len (blk_part_len),
      .eng_req      (eng_tx_pop),
      .wr_ptr_o     (tx_wr),
      .rd_ptr_o     (tx_rd),
      .fill_o       (tx_fill),
      .flag_o       (tx_wm_room),
      .busy_o       (tx_flush_busy),
      .err_o        (tx_ovf),
      .sw_fire_o    (tx_sw_fire),
      .sw_n_o       (tx_sw_n),
      .eng_fire_o   (tx_eng_fire)
   );

   wmf_tx_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_tx_store (
      .clk       (clk),
      .win_we    (tx_win_we),
      .win_idx   (tx_win_idx),
      .win_wdata (tx_win_wdata),
      .push_fire (tx_sw_fire),
      .push_n    (tx_sw_n),
      .wr_ptr    (tx_wr),
      .rd_ptr    (tx_rd),
      .head_data (eng_tx_data)
   );

   wmf_ctrl #(.DEPTH(DEPTH), .SW_WRITES(1'b0)) u_rx_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_req    (rx_flush),
      .wm_we        (rx_wm_we),
      .wm_wdata     (wm_wdata),
      .sw_req       (rx_pop),
      .blk_partial  (blk_partial),
      .blk_part_len (blk_part_len),
      .eng_req      (eng_rx_push),
      .wr_ptr_o     (rx_wr),
      .rd_ptr_o     (rx_rd),
      .fill_o       (rx_fill),
      .flag_o       (rx_wm_avail),
      .busy_o       (rx_flush_busy),
      .err_o        (rx_unf),
      .sw_fire_o    (rx_sw_fire),
      .sw_n_o       (rx_sw_n),
      .eng_fire_o   (rx_eng_fire)
   );

   wmf_rx_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_rx_store (
      .clk       (clk),
      .wr_fire   (rx_eng_fire),
      .wr_data   (eng_rx_data),
      .wr_ptr    (rx_wr),
      .rd_ptr    (rx_rd),
      .win_idx   (rx_win_idx),
      .win_rdata (rx_win_rdata)
   );

   // R4: room flag implies the FIFO is not full
   p_tx_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wm_room |-> (tx_fill < CNT_W'(DEPTH)));
   // R5: available flag implies at least one entry
   p_rx_avail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wm_avail |-> (rx_fill != '0));
   // R11: a lone engine pop removes exactly one entry
   p_tx_pop_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_eng_fire && !tx_sw_fire) |=> (tx_fill == $past(tx_fill) - CNT_W'(1)));
   // R6 / R7: a lone block pop removes exactly its length
   p_rx_pop_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_sw_fire && !rx_eng_fire) |=> (rx_fill == $past(rx_fill) - $past(rx_sw_n)));
endmodule

// File: tb/tb_wm_ip_fifo.sv
module tb_wm_ip_fifo;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_wm_we = 0, rx_wm_we = 0;
   logic [3:0]  wm_wdata = '0;
   logic        tx_win_we = 0;
   logic [4:0]  tx_win_idx = '0;
   logic [31:0] tx_win_wdata = '0;
   logic        tx_push = 0, rx_pop = 0, blk_partial = 0;
   logic [3:0]  blk_part_len = '0;
   logic        tx_flush = 0, rx_flush = 0;
   logic [4:0]  rx_win_idx = '0;
   logic        eng_tx_pop = 0, eng_rx_push = 0;
   logic [63:0] eng_rx_data = '0;
   logic [31:0] rx_win_rdata;
   logic        tx_wm_room, rx_wm_avail, tx_flush_busy, rx_flush_busy, tx_ovf, rx_unf;
   logic [4:0]  tx_fill, rx_fill;
   logic [63:0] eng_tx_data;

   wm_ip_fifo #(.DEPTH(DEPTH), .WORD_W(32)) dut (.*);

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0, seq = 0;
   string phase = "R1";

   // behavioural reference
   logic [63:0] m_txq[$], m_rxq[$];
   logic [31:0] m_stage [2*DEPTH];
   int m_txf = 0, m_rxf = 0;
   bit m_txp = 0, m_rxp = 0, m_ovf = 0, m_unf = 0;

   always @(posedge clk) begin
      int nt, nr;
      bit ok, eok;
      if (!rst_n) begin
         m_txq.delete(); m_rxq.delete();
         m_txf = 0; m_rxf = 0; m_txp = 0; m_rxp = 0; m_ovf = 0; m_unf = 0;
      end else begin
         nt = blk_partial ? int'(blk_part_len) + 1 : m_txf + 1;
         nr = blk_partial ? int'(blk_part_len) + 1 : m_rxf + 1;
         if (m_txp) begin
            m_txq.delete(); m_txp = 0; m_ovf = 0;
         end else begin
            ok = tx_push && (DEPTH - m_txq.size()) >= nt;
            eok = eng_tx_pop && m_txq.size() > 0;
            m_ovf = tx_push && !ok;
            if (eok) void'(m_txq.pop_front());
            if (ok) for (int k = 0; k < nt; k++) m_txq.push_back({m_stage[2*k+1], m_stage[2*k]});
            m_txp = tx_flush;
         end
         if (m_rxp) begin
            m_rxq.delete(); m_rxp = 0; m_unf = 0;
         end else begin
            ok = rx_pop && m_rxq.size() >= nr;
            eok = eng_rx_push && m_rxq.size() < DEPTH;
            m_unf = rx_pop && !ok;
            if (ok) for (int k = 0; k < nr; k++) void'(m_rxq.pop_front());
            if (eok) m_rxq.push_back(eng_rx_data);
            m_rxp = rx_flush;
         end
         if (tx_win_we) m_stage[tx_win_idx] = tx_win_wdata;
         if (tx_wm_we) m_txf = int'(wm_wdata);
         if (rx_wm_we) m_rxf = int'(wm_wdata);
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [phase %s] actual=%0h expected=%0h", req, phase, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R3 tx_fill", 64'(tx_fill), 64'(m_txq.size()));
      chk("R6 rx_fill", 64'(rx_fill), 64'(m_rxq.size()));
      chk("R4 tx_wm_room", 64'(tx_wm_room), 64'((DEPTH - m_txq.size()) >= m_txf + 1));
      chk("R5 rx_wm_avail", 64'(rx_wm_avail), 64'(m_rxq.size() >= m_rxf + 1));
      chk("R8 tx_ovf", 64'(tx_ovf), 64'(m_ovf));
      chk("R9 rx_unf", 64'(rx_unf), 64'(m_unf));
      chk("R10 tx_flush_busy", 64'(tx_flush_busy), 64'(m_txp));
      chk("R10 rx_flush_busy", 64'(rx_flush_busy), 64'(m_rxp));
      if (m_txq.size() > 0) chk("R11 eng_tx_data", eng_tx_data, m_txq[0]);
      if (int'(rx_win_idx >> 1) < m_rxq.size())
         chk("R6 rx_win_rdata", 64'(rx_win_rdata),
             rx_win_idx[0] ? 64'(m_rxq[rx_win_idx >> 1][63:32]) : 64'(m_rxq[rx_win_idx >> 1][31:0]));
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
      tx_push = 0; rx_pop = 0; tx_win_we = 0; tx_wm_we = 0; rx_wm_we = 0;
      tx_flush = 0; rx_flush = 0; eng_tx_pop = 0; eng_rx_push = 0; blk_partial = 0;
   endtask

   task automatic stage(int words);
      for (int i = 0; i < words; i++) begin
         tx_win_we = 1; tx_win_idx = 5'(i); tx_win_wdata = 32'hC0DE_0000 + 32'(seq); seq++;
         tick();
      end
   endtask

   task automatic eng_in(int n);
      for (int i = 0; i < n; i++) begin
         eng_rx_push = 1; eng_rx_data = {32'hAB00_0000 + 32'(seq), 32'h1234_0000 + 32'(seq)}; seq++;
         tick();
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 tx_fill", 64'(tx_fill), 0);
      chk("R1 rx_fill", 64'(rx_fill), 0);
      chk("R1 tx_wm_room", 64'(tx_wm_room), 1);
      chk("R1 rx_wm_avail", 64'(rx_wm_avail), 0);
      chk("R1 busy", 64'({tx_flush_busy, rx_flush_busy}), 0);
      chk("R1 errors", 64'({tx_ovf, rx_unf}), 0);
      // R2: default field 0 means one-entry block
      phase = "R2 default";
      eng_in(1);
      chk("R2 rx_wm_avail one entry", 64'(rx_wm_avail), 1);
      phase = "R10 rx"; rx_flush = 1; tick(); tick();
      chk("R10 rx emptied", 64'(rx_fill), 0);

      // R2/R3/R4: four-entry transmit blocks to full
      phase = "R3 R4";
      tx_wm_we = 1; wm_wdata = 4'd3; tick();
      for (int b = 0; b < 4; b++) begin
         stage(8); tx_push = 1; tick();
      end
      chk("R4 full no room", 64'(tx_wm_room), 0);
      chk("R3 full fill", 64'(tx_fill), 16);
      phase = "R8"; stage(8); tx_push = 1; tick(); tick();
      chk("R8 fill kept", 64'(tx_fill), 16);
      phase = "R11 drain";
      for (int i = 0; i < 17; i++) begin eng_tx_pop = 1; tick(); end
      chk("R11 empty after drain", 64'(tx_fill), 0);

      phase = "R7 tx partial";
      stage(4); blk_partial = 1; blk_part_len = 4'd1; tx_push = 1; tick();
      chk("R7 partial push", 64'(tx_fill), 2);
      phase = "R12 tx";
      stage(8); tx_push = 1; eng_tx_pop = 1; tick();
      chk("R12 push and pop", 64'(tx_fill), 5);
      phase = "R10 tx";
      tx_flush = 1; tick();
      chk("R10 busy", 64'(tx_flush_busy), 1);
      tx_push = 1; tick();
      chk("R10 emptied, push dropped", 64'(tx_fill), 0);
      chk("R10 no error", 64'(tx_ovf), 0);

      phase = "R2 whole depth";
      tx_wm_we = 1; wm_wdata = 4'd15; tick();
      chk("R2 room empty", 64'(tx_wm_room), 1);
      stage(2); blk_partial = 1; blk_part_len = 4'd0; tx_push = 1; tick();
      chk("R2 room gone", 64'(tx_wm_room), 0);
      eng_tx_pop = 1; tick();

      phase = "R5 R6 rx";
      rx_wm_we = 1; wm_wdata = 4'd1; tick();
      eng_in(5);
      for (int i = 0; i < 4; i++) begin rx_win_idx = 5'(i); tick(); end
      rx_pop = 1; tick();
      chk("R6 pop block", 64'(rx_fill), 3);
      for (int i = 0; i < 2; i++) begin rx_win_idx = 5'(i); tick(); end
      rx_pop = 1; tick();
      phase = "R9"; rx_pop = 1; tick(); tick();
      chk("R9 fill kept", 64'(rx_fill), 1);
      phase = "R7 rx partial";
      blk_partial = 1; blk_part_len = 4'd0; rx_pop = 1; tick();
      chk("R7 partial pop", 64'(rx_fill), 0);
      phase = "R11 rx full";
      eng_in(17);
      chk("R11 push into full ignored", 64'(rx_fill), 16);
      phase = "R12 rx";
      rx_pop = 1; eng_rx_push = 1; eng_rx_data = 64'hDEAD_BEEF_0BAD_F00D; tick();
      chk("R12 judged on old fill", 64'(rx_fill), 14);
      rx_win_idx = 5'd3; tick();
      phase = "R10 rx2"; rx_flush = 1; tick(); tick();
      chk("R10 rx emptied again", 64'(rx_fill), 0);
      tick();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule